// File: doc/BRIEF.md
# Snapshot Match Timer

A memory-mapped system timer built around a free-running 64-bit up-counter. A programmable prescaler sets how often the counter advances. Software reads a consistent 64-bit time by first issuing a snapshot command, which copies both counter words at once into a pair of read-only holding registers, and then reading those two words at leisure.

Six 32-bit compare channels watch the low counter word. When an advance of the counter makes the low word equal a channel's compare value, that channel's sticky status flag sets. The comparison is modulo 2^32, so software can arm an event with "now + delta". Each flag can be routed onto a single interrupt line through an enable mask. The last channel can also drive a one-clock watchdog-reset pulse when the watchdog arm bit is set.

The block sits on a simple 32-bit register bus with word addresses and single-cycle writes. Read data is registered and returned one clock after the read strobe.

Top module: `snap_match_timer`

## Requirements
- R1: The counter advances by exactly one every 2×(DIV+1) clocks, where DIV is the prescaler register at word address 11. Only the low DIV_W bits of a write are kept.
- R2: The counter words are writable at word address 0 (low) and 1 (high). A write takes priority over an increment in the same cycle. An increment carries from the low word into the high word.
- R3: Writing a word with bit 0 set to word address 12 copies the whole 64-bit counter into the snapshot registers, read at word address 13 (low) and 14 (high). Word address 12 always reads zero.
- R4: Channel n has its compare register at word address 2+n. The channel's event occurs when a counter advance makes the low word equal the compare value, wrapping modulo 2^32. A software write that places the counter on the compare value causes no event.
- R5: Word address 8 holds the status flags, bit n for channel n. A flag stays set after its event until software writes 1 to that bit. Writing 0 leaves the bit unchanged.
- R6: Word address 9 holds an N_CH-bit enable mask. irq_o is high one clock after some status bit is set while its enable bit is set, and low one clock after no such bit remains.
- R7: Bit 0 of word address 10 arms the watchdog. While it is set, an event on channel N_CH-1 drives wdog_rst_o high for exactly one clock, in the same cycle the status bit sets. While it is clear, that channel still sets its status bit but gives no pulse.
- R8: After reset, the counter, compare, status, enable, watchdog, prescaler and snapshot registers are all zero, and irq_o, wdog_rst_o and rd_data_o are low.
- R9: A read strobe returns the addressed register on rd_data_o after the next clock edge. The value is zero-extended from the register's width, and unmapped word addresses (15) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Word address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, OR of enabled status flags |
| wdog_rst_o | output | 1 | One-clock watchdog reset pulse |

## Verification
A wrong prescaler phase or an increment that is dropped or doubled appears as a wrong difference between two snapshots taken a known number of clocks apart. Snapshot intervals of 60 clocks at three divider settings expose such an error within one interval. A compare or flag error shows on the status read and on irq_o one clock after the event. A missed carry or lost write priority is visible on the very next snapshot. A watchdog fault shows as a missing, extra or stretched wdog_rst_o pulse in the cycle the status bit sets.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd1;
  localparam int                MATCH_BASE = 2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd8;
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = 4'd9;
  localparam logic [ADDR_W-1:0] A_WD_ARM  = 4'd10;
  localparam logic [ADDR_W-1:0] A_DIV     = 4'd11;
  localparam logic [ADDR_W-1:0] A_SNAP    = 4'd12;
  localparam logic [ADDR_W-1:0] A_SNAP_LO = 4'd13;
  localparam logic [ADDR_W-1:0] A_SNAP_HI = 4'd14;
endpackage

// File: rtl/smt_prescale.sv
module smt_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PC_W = DIV_W + 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] limit;

  // period 2*(div+1): terminal count is 2*div+1
  assign limit  = {div_i, 1'b1};
  assign tick_o = (pc_q >= limit);

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else             pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/smt_counter.sv
module smt_counter #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0]   nxt_lo_o,
  output logic                adv_o
);
  logic [2*DATA_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign nxt_lo_o = cnt_q[DATA_W-1:0] + 1'b1;
  assign adv_o    = tick_i && !wr_lo_i && !wr_hi_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_q[DATA_W-1:0]        <= wdata_i;
      if (wr_hi_i) cnt_q[2*DATA_W-1:DATA_W] <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/smt_match_chan.sv
module smt_match_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] nxt_lo_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] match_o,
  output logic              ev_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] match_q;
  logic              flag_q;

  assign match_o = match_q;
  assign flag_o  = flag_q;
  // event when the coming advance lands on the compare value
  assign ev_o    = adv_i && (nxt_lo_i == match_q);

  always_ff @(posedge clk) begin
    if (rst)       match_q <= '0;
    else if (wr_i) match_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (ev_o)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/snap_match_timer.sv
module snap_match_timer
  import smt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_CH   = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  localparam int WDOG_CH = N_CH - 1;

  logic                tick_w;
  logic                cnt_wr_lo, cnt_wr_hi, cnt_wr_w;
  logic [2*DATA_W-1:0] cnt_w;
  logic [DATA_W-1:0]   nxt_lo_w;
  logic                adv_w;
  logic                latch_wr_w;
  logic [2*DATA_W-1:0] lat_q;
  logic [DIV_W-1:0]    div_q;
  logic [N_CH-1:0]     ie_q;
  logic                wde_q;
  logic [N_CH-1:0]     ev_w;
  logic [N_CH-1:0]     flag_w;
  logic [N_CH-1:0]     clr_w;
  logic [DATA_W-1:0]   match_w [N_CH];
  logic [DATA_W-1:0]   rd_val;

  assign cnt_wr_lo  = wr_en_i && (addr_i == A_CNT_LO);
  assign cnt_wr_hi  = wr_en_i && (addr_i == A_CNT_HI);
  assign cnt_wr_w   = cnt_wr_lo || cnt_wr_hi;
  assign latch_wr_w = wr_en_i && (addr_i == A_SNAP) && wr_data_i[0];
  assign clr_w      = (wr_en_i && (addr_i == A_STATUS)) ? wr_data_i[N_CH-1:0] : '0;

  smt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .div_i (div_q),
    .tick_o(tick_w)
  );

  smt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_w),
    .wr_lo_i (cnt_wr_lo),
    .wr_hi_i (cnt_wr_hi),
    .wdata_i (wr_data_i),
    .cnt_o   (cnt_w),
    .nxt_lo_o(nxt_lo_w),
    .adv_o   (adv_w)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic wr_m;
    assign wr_m = wr_en_i && (addr_i == ADDR_W'(MATCH_BASE + n));
    smt_match_chan #(.DATA_W(DATA_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (wr_m),
      .wdata_i (wr_data_i),
      .adv_i   (adv_w),
      .nxt_lo_i(nxt_lo_w),
      .clr_i   (clr_w[n]),
      .match_o (match_w[n]),
      .ev_o    (ev_w[n]),
      .flag_o  (flag_w[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      ie_q  <= '0;
      wde_q <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_DIV)    div_q <= wr_data_i[DIV_W-1:0];
      if (addr_i == A_IRQ_EN) ie_q  <= wr_data_i[N_CH-1:0];
      if (addr_i == A_WD_ARM) wde_q <= wr_data_i[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             lat_q <= '0;
    else if (latch_wr_w) lat_q <= cnt_w;
  end

  always_comb begin
    rd_val = '0;
    case (addr_i)
      A_CNT_LO:  rd_val = cnt_w[DATA_W-1:0];
      A_CNT_HI:  rd_val = cnt_w[2*DATA_W-1:DATA_W];
      A_STATUS:  rd_val = {{(DATA_W-N_CH){1'b0}}, flag_w};
      A_IRQ_EN:  rd_val = {{(DATA_W-N_CH){1'b0}}, ie_q};
      A_WD_ARM:  rd_val = {{(DATA_W-1){1'b0}}, wde_q};
      A_DIV:     rd_val = {{(DATA_W-DIV_W){1'b0}}, div_q};
      A_SNAP_LO: rd_val = lat_q[DATA_W-1:0];
      A_SNAP_HI: rd_val = lat_q[2*DATA_W-1:DATA_W];
      default:   rd_val = '0;
    endcase
    for (int n = 0; n < N_CH; n++) begin
      if (addr_i == ADDR_W'(MATCH_BASE + n)) rd_val = match_w[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      irq_o      <= 1'b0;
      wdog_rst_o <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_val;
      irq_o      <= |(flag_w & ie_q);
      wdog_rst_o <= wde_q && ev_w[WDOG_CH];
    end
  end
endmodule

// File: rtl/smt_chk.sv
module smt_chk #(
  parameter int DATA_W = 32,
  parameter int N_CH   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                cnt_wr,
  input logic [2*DATA_W-1:0] cnt,
  input logic                latch_wr,
  input logic [2*DATA_W-1:0] lat,
  input logic [N_CH-1:0]     ev,
  input logic [N_CH-1:0]     flag,
  input logic [N_CH-1:0]     ie,
  input logic                wde,
  input logic                rd_en,
  input logic [3:0]          addr,
  input logic [DATA_W-1:0]   rdata,
  input logic                irq_o,
  input logic                wdog_rst_o
);
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(cnt));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

  // R3
  snap_copy_chk: assert property (@(posedge clk) disable iff (rst)
    latch_wr |=> (lat == $past(cnt)));

  // R3
  snap_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 4'd12) |=> (rdata == '0));

  for (genvar n = 0; n < N_CH; n++) begin : g_f
    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (!flag[n] && !ev[n]) |=> !flag[n]);
  end

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((flag & ie) == '0) |=> !irq_o);

  // R7
  wdog_width_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |=> !wdog_rst_o);

  // R7
  wdog_armed_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |-> ($past(wde) && flag[N_CH-1]));
endmodule

bind snap_match_timer smt_chk #(.DATA_W(DATA_W), .N_CH(N_CH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick_w),
  .cnt_wr    (cnt_wr_w),
  .cnt       (cnt_w),
  .latch_wr  (latch_wr_w),
  .lat       (lat_q),
  .ev        (ev_w),
  .flag      (flag_w),
  .ie        (ie_q),
  .wde       (wde_q),
  .rd_en     (rd_en_i),
  .addr      (addr_i),
  .rdata     (rd_data_o),
  .irq_o     (irq_o),
  .wdog_rst_o(wdog_rst_o)
);

// File: tb/snap_match_timer_tb_top.sv
module snap_match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        wdog;

  int n_vec = 0;
  int n_bad = 0;
  int wd_pulses = 0;
  int wd_long = 0;
  logic wd_prev = 1'b0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  snap_match_timer dut_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq),
    .wdog_rst_o(wdog)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wdog && !wd_prev) wd_pulses++;
      if (wdog && wd_prev)  wd_long++;
    end
    wd_prev = wdog;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic run_for(input int n);
    bus_write(4'd11, 32'h0);
    repeat (n) @(negedge clk);
    bus_write(4'd11, 32'hFFFF);
  endtask

  typedef struct packed {
    logic        rd;
    logic [3:0]  rq;
    logic [3:0]  a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VTAB [NV] = '{
    '{1'b1, 4'd8, 4'd13, 32'h0},            // R8 snapshot low
    '{1'b1, 4'd8, 4'd14, 32'h0},            // R8 snapshot high
    '{1'b1, 4'd8, 4'd8,  32'h0},            // R8 status
    '{1'b1, 4'd8, 4'd9,  32'h0},            // R8 enable
    '{1'b1, 4'd8, 4'd10, 32'h0},            // R8 watchdog arm
    '{1'b1, 4'd8, 4'd11, 32'h0},            // R8 divider
    '{1'b1, 4'd8, 4'd2,  32'h0},            // R8 compare 0
    '{1'b1, 4'd8, 4'd7,  32'h0},            // R8 compare 5
    '{1'b0, 4'd1, 4'd11, 32'h0000FFFF},     // R1 slow prescaler
    '{1'b1, 4'd9, 4'd11, 32'h0000FFFF},
    '{1'b0, 4'd2, 4'd0,  32'hFFFFFFFF},     // R2 counter low write
    '{1'b0, 4'd2, 4'd1,  32'h00000005},     // R2 counter high write
    '{1'b0, 4'd3, 4'd12, 32'h00000001},     // R3 snapshot
    '{1'b1, 4'd3, 4'd13, 32'hFFFFFFFF},
    '{1'b1, 4'd3, 4'd14, 32'h00000005},
    '{1'b1, 4'd3, 4'd12, 32'h0},            // R3 command reads zero
    '{1'b1, 4'd2, 4'd1,  32'h00000005},
    '{1'b1, 4'd2, 4'd0,  32'hFFFFFFFF},
    '{1'b0, 4'd9, 4'd2,  32'h00001234},
    '{1'b1, 4'd9, 4'd2,  32'h00001234},
    '{1'b0, 4'd9, 4'd7,  32'hCAFE0001},
    '{1'b1, 4'd9, 4'd7,  32'hCAFE0001},
    '{1'b0, 4'd9, 4'd9,  32'hFFFFFFFF},
    '{1'b1, 4'd9, 4'd9,  32'h0000003F},     // R9 masked width
    '{1'b0, 4'd9, 4'd10, 32'hFFFFFFFF},
    '{1'b1, 4'd9, 4'd10, 32'h00000001},
    '{1'b0, 4'd9, 4'd10, 32'h0},
    '{1'b1, 4'd9, 4'd15, 32'h0},            // R9 unmapped
    '{1'b0, 4'd4, 4'd3,  32'h00000777},     // R4 compare 1
    '{1'b0, 4'd4, 4'd0,  32'h00000777},     // R4 write onto compare value
    '{1'b1, 4'd4, 4'd8,  32'h0},            // R4 no event from write
    '{1'b0, 4'd6, 4'd9,  32'h0}
  };

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, a0, b0;
    repeat (4) @(negedge clk);
    // R8 outputs during reset
    check("R8 irq", {31'b0, irq}, 32'h0);
    check("R8 wdog", {31'b0, wdog}, 32'h0);
    check("R8 rdata", rdata, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VTAB[i].rd) begin
        bus_read(VTAB[i].a, v);
        check($sformatf("R%0d vec%0d", VTAB[i].rq, i), v, VTAB[i].d);
      end else begin
        bus_write(VTAB[i].a, VTAB[i].d);
      end
    end

    // R1: snapshots 60 clocks apart at three divider settings
    for (int k = 0; k < 3; k++) begin
      int dv;
      dv = 2 * k;
      bus_write(4'd11, dv);
      repeat (12) @(negedge clk);
      bus_write(4'd12, 32'h1);
      bus_read(4'd13, a0);
      repeat (58) @(negedge clk);
      bus_write(4'd12, 32'h1);
      bus_read(4'd13, b0);
      check($sformatf("R1 div=%0d", dv), b0 - a0, 32'(60 / (2 * (dv + 1))));
    end

    // R2: write wins over same-cycle increment, both prescaler phases
    bus_write(4'd11, 32'h0);
    for (int ph = 0; ph < 2; ph++) begin
      repeat (ph + 3) @(negedge clk);
      bus_write(4'd0, 32'h50 + ph);
      bus_write(4'd12, 32'h1);
      bus_read(4'd13, v);
      check("R2 write priority", v, 32'h50 + ph);
    end
    bus_write(4'd11, 32'hFFFF);

    // set all compares away from the test windows
    for (int n = 0; n < 6; n++) bus_write(4'(2 + n), 32'hAAAA0000);
    bus_write(4'd8, 32'h3F);

    // R4 R5 R6: events on channels 0 and 3
    bus_write(4'd1, 32'h0);
    bus_write(4'd0, 32'd100);
    bus_write(4'd2, 32'd105);
    bus_write(4'd5, 32'd103);
    bus_write(4'd9, 32'h01);
    run_for(30);
    bus_read(4'd8, v);
    check("R4 events", v, 32'h09);
    check("R6 irq enabled", {31'b0, irq}, 32'h1);
    bus_write(4'd9, 32'h10);
    @(negedge clk);
    check("R6 irq masked", {31'b0, irq}, 32'h0);
    bus_write(4'd9, 32'h08);
    @(negedge clk);
    check("R6 irq ch3", {31'b0, irq}, 32'h1);
    bus_write(4'd8, 32'h08);
    @(negedge clk);
    check("R6 irq after clear", {31'b0, irq}, 32'h0);
    bus_read(4'd8, v);
    check("R5 clear one bit", v, 32'h01);
    bus_write(4'd8, 32'h0);
    bus_read(4'd8, v);
    check("R5 zero write keeps", v, 32'h01);
    bus_write(4'd8, 32'h01);
    bus_read(4'd8, v);
    check("R5 cleared", v, 32'h0);
    bus_write(4'd9, 32'h0);

    // R2 carry and R4 modulo wrap
    bus_write(4'd1, 32'h7);
    bus_write(4'd0, 32'hFFFFFFFE);
    bus_write(4'd3, 32'h1);
    run_for(20);
    bus_write(4'd12, 32'h1);
    bus_read(4'd14, v);
    check("R2 carry", v, 32'h8);
    bus_read(4'd8, v);
    check("R4 wrap", v, 32'h02);
    bus_write(4'd8, 32'h3F);

    // R7 armed watchdog
    bus_write(4'd0, 32'd200);
    bus_write(4'd7, 32'd203);
    bus_write(4'd10, 32'h1);
    wd_pulses = 0;
    run_for(20);
    check("R7 one pulse", wd_pulses, 32'd1);
    check("R7 pulse width", wd_long, 32'd0);
    bus_read(4'd8, v);
    check("R7 status armed", v, 32'h20);

    // R7 disarmed: status only
    bus_write(4'd10, 32'h0);
    bus_write(4'd8, 32'h3F);
    bus_write(4'd0, 32'd300);
    bus_write(4'd7, 32'd303);
    run_for(20);
    check("R7 no pulse", wd_pulses, 32'd1);
    bus_read(4'd8, v);
    check("R7 status disarmed", v, 32'h20);

    finish_run();
  end
endmodule